// File: doc/BRIEF.md
# Message-Signaled Interrupt Capability

This block is the interrupt-message capability of one endpoint function. It holds the capability registers: a control word, a message address, a message data value and, when per-vector masking is built in, a mask and a pending register. An external configuration decoder drives dword-indexed, byte-enabled reads and writes into it. Inside the function, interrupt sources raise a vector number on a valid/ready request port. The block turns each accepted request into one memory-write message, carrying a 64-bit address and a 32-bit data word, on a valid/ready message port.

Parameters select the capable vector count (log2, 0 to 5), 32-bit or 64-bit addressing, and whether per-vector masking exists. When a request arrives on a masked vector, the block stores it as a pending bit and sends nothing. After a configuration write that touches the capability while messaging is enabled, three things happen in turn. The block pulses a legacy-interrupt deassert. It clamps an enabled count that is set too large. It drops stale pending bits, then replays the unmasked pending ones one at a time, lowest vector first, before it takes new requests again.

Top module: `msi_cap_unit`

## Requirements
- R1: After reset, control dword 0 reads 0x0186_0000 for the default build (enable 0, enabled-count 0, capable-count 3 in control bits [3:1], 64-bit flag at bit 7, mask-capable flag at bit 8, control word in bits [31:16]). The address, data, mask and pending dwords read zero.
- R2: Address bits [1:0] read zero. The upper address dword (dword 2) is writable in 64-bit mode. Only bits [15:0] of the data dword are stored. Writes merge per byte lane.
- R3: Only mask bits 0 to N-1 are writable, where N is the capable vector count. The other mask bits read zero.
- R4: The capable-count field, the 64-bit flag and the mask-capable flag ignore writes.
- R5: An accepted request on an unmasked, in-range vector while enabled produces exactly one message. The message address is the stored address. Data bits [31:16] are zero. When the enabled count E (control bits [6:4], log2) is above 0, the low E data bits are replaced by the vector number; otherwise the data passes unchanged.
- R6: An accepted request on a masked vector sets its pending bit and produces no message.
- R7: A request with the enable bit (control bit 0) clear, or with a vector at or above 2^E, sets no pending bit and produces no message.
- R8: One cycle after a write that has an enabled byte lane inside the capability's byte range, with enable set, intx_deassert pulses for one cycle. A write outside that range, or with no enabled byte lane, gives no pulse.
- R9: After such a write, an enabled-count field above the capable count is clamped to the capable count.
- R10: After such a write with masking built in, pending bits at or above 2^E are dropped. Each remaining unmasked pending bit is cleared and its message sent, in ascending vector order.
- R11: A message keeps address and data stable until accepted, and only one message is outstanding. The request port is not ready while a message waits or a post-write replay is running.
- R12: The pending register is read-only at dword 5 in the 64-bit layout (dword 4 in the 32-bit layout), and the mask register sits one dword below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 3 | Dword index within the capability for reads and writes |
| cfg_be | input | 4 | Byte enables of a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for dword cfg_dw (combinational) |
| irq_valid | input | 1 | Interrupt request valid |
| irq_vec | input | 5 | Requested vector number |
| irq_ready | output | 1 | Request accepted when high with irq_valid |
| msg_valid | output | 1 | Message write valid |
| msg_ready | input | 1 | Message accepted by the transaction layer |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |
| intx_deassert | output | 1 | One-cycle pulse requesting legacy interrupt deassert |

## Verification
The checks assume a transaction layer that raises msg_ready only while it can take a message. They also assume a configuration decoder that issues at most one write per cycle, with cfg_dw and cfg_be stable for that cycle. The stimulus keeps irq_valid high until the request is taken and drives inputs only on the falling edge. It lets each write's post-processing finish before a register is read back. Vectors outside the enabled range are still sent on purpose, because dropping them is specified behaviour.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam int unsigned VEC_MAX = 32;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;

  // Bitmap with one bit set per vector of a 2^lg vector group.
  function automatic logic [VEC_MAX-1:0] vec_span(input logic [2:0] lg);
    logic [VEC_MAX-1:0] r;
    r = '0;
    for (int i = 0; i < VEC_MAX; i++) begin
      if (i < (1 << lg)) r[i] = 1'b1;
    end
    return r;
  endfunction

  // Per-lane merge of a write into an old dword.
  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    end
    return r;
  endfunction

  // Byte footprint of the capability for each build variant.
  function automatic int unsigned cap_bytes(input bit wide, input bit maskable);
    if (wide) return maskable ? 24 : 14;
    return maskable ? 20 : 10;
  endfunction

endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          MASKING  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         dw_idx,
  input  logic [3:0]         wr_be,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic               wr_hit,
  input  logic               post_step,
  input  logic [VEC_MAX-1:0] pend_set,
  input  logic [VEC_MAX-1:0] pend_clr,
  output logic               en,
  output logic [2:0]         qsize,
  output logic [63:0]        addr,
  output logic [15:0]        data16,
  output logic [VEC_MAX-1:0] mask,
  output logic [VEC_MAX-1:0] pend
);

  localparam int unsigned     CAP_BYTES = cap_bytes(ADDR64, MASKING);
  localparam logic [2:0]      CAP_Q     = 3'(CAP_LOG2);
  localparam logic [VEC_MAX-1:0] CAP_SPAN = vec_span(CAP_Q);
  localparam logic [2:0]      IDX_LO    = 3'd1;
  localparam logic [2:0]      IDX_HI    = 3'd2;
  localparam logic [2:0]      IDX_DATA  = ADDR64 ? 3'd3 : 3'd2;
  localparam logic [2:0]      IDX_MASK  = ADDR64 ? 3'd4 : 3'd3;
  localparam logic [2:0]      IDX_PEND  = ADDR64 ? 3'd5 : 3'd4;

  logic               en_q, en_d;
  logic [2:0]         qs_q, qs_d;
  logic [31:2]        alo_q, alo_d;
  logic [31:0]        ahi_q, ahi_d;
  logic [15:0]        dat_q, dat_d;
  logic [VEC_MAX-1:0] msk_q, msk_d;
  logic [VEC_MAX-1:0] pnd_q, pnd_d;
  logic               in_range;

  // Does any enabled byte lane land inside the capability?
  always_comb begin
    in_range = 1'b0;
    for (int l = 0; l < 4; l++) begin
      logic [4:0] boff;
      boff = {dw_idx, l[1:0]};
      if (wr_be[l] && (32'(boff) < CAP_BYTES)) in_range = 1'b1;
    end
  end

  assign wr_hit = wr_en && in_range;

  // Next-state logic
  always_comb begin
    logic [31:0] mrg;
    mrg   = '0;
    en_d  = en_q;
    qs_d  = qs_q;
    alo_d = alo_q;
    ahi_d = ahi_q;
    dat_d = dat_q;
    msk_d = msk_q;
    if (wr_en) begin
      if (dw_idx == 3'd0 && wr_be[2]) begin
        en_d = wr_data[16];
        qs_d = wr_data[22:20];
      end
      if (dw_idx == IDX_LO) begin
        mrg   = lane_merge({alo_q, 2'b00}, wr_data, wr_be);
        alo_d = mrg[31:2];
      end
      if (ADDR64 && dw_idx == IDX_HI) begin
        ahi_d = lane_merge(ahi_q, wr_data, wr_be);
      end
      if (dw_idx == IDX_DATA) begin
        mrg   = lane_merge({16'h0000, dat_q}, wr_data, wr_be);
        dat_d = mrg[15:0];
      end
      if (MASKING && dw_idx == IDX_MASK) begin
        msk_d = lane_merge(msk_q, wr_data, wr_be) & CAP_SPAN;
      end
    end
    pnd_d = (pnd_q & ~pend_clr) | pend_set;
    if (post_step && en_q) begin
      if (qs_d > CAP_Q) qs_d = CAP_Q;
      pnd_d = pnd_d & vec_span(qs_d);
    end
    pnd_d = MASKING ? (pnd_d & CAP_SPAN) : '0;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      qs_q  <= '0;
      alo_q <= '0;
      ahi_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      pnd_q <= '0;
    end else begin
      en_q  <= en_d;
      qs_q  <= qs_d;
      alo_q <= alo_d;
      ahi_q <= ahi_d;
      dat_q <= dat_d;
      msk_q <= msk_d;
      pnd_q <= pnd_d;
    end
  end

  // Readback
  always_comb begin
    rd_data = '0;
    if (dw_idx == 3'd0) begin
      rd_data = {7'b0, MASKING, ADDR64, qs_q, CAP_Q, en_q, 16'h0000};
    end else if (dw_idx == IDX_LO) begin
      rd_data = {alo_q, 2'b00};
    end else if (ADDR64 && dw_idx == IDX_HI) begin
      rd_data = ahi_q;
    end else if (dw_idx == IDX_DATA) begin
      rd_data = {16'h0000, dat_q};
    end else if (MASKING && dw_idx == IDX_MASK) begin
      rd_data = msk_q;
    end else if (MASKING && dw_idx == IDX_PEND) begin
      rd_data = pnd_q;
    end
  end

  assign en     = en_q;
  assign qsize  = qs_q;
  assign addr   = ADDR64 ? {ahi_q, alo_q, 2'b00} : {32'h0, alo_q, 2'b00};
  assign data16 = dat_q;
  assign mask   = msk_q;
  assign pend   = pnd_q;

endmodule

// File: rtl/msi_cap_seq.sv
module msi_cap_seq
  import msi_cap_pkg::*;
#(
  parameter bit MASKING = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  logic               en,
  input  logic [2:0]         qsize,
  input  logic [VEC_MAX-1:0] mask,
  input  logic [VEC_MAX-1:0] pend,
  input  logic               irq_valid,
  input  logic [4:0]         irq_vec,
  input  logic               slot_free,
  output logic               irq_ready,
  output logic               post_step,
  output logic               sweeping,
  output logic               launch,
  output logic [4:0]         launch_vec,
  output logic [VEC_MAX-1:0] pend_set,
  output logic [VEC_MAX-1:0] pend_clr,
  output logic               intx_deassert
);

  logic               post_q;
  logic               sweep_q, sweep_d;
  logic [VEC_MAX-1:0] cand;
  logic [4:0]         first;
  logic               found;
  logic               vec_ok;

  // Lowest unmasked pending vector inside the enabled range.
  always_comb begin
    cand  = pend & ~mask & vec_span(qsize);
    first = '0;
    found = 1'b0;
    for (int i = 0; i < VEC_MAX; i++) begin
      if (!found && cand[i]) begin
        first = 5'(i);
        found = 1'b1;
      end
    end
  end

  assign vec_ok    = (qsize >= 3'd5) || ((irq_vec >> qsize) == 5'd0);
  assign irq_ready = slot_free && !post_q && !sweep_q;

  always_comb begin
    launch     = 1'b0;
    launch_vec = irq_vec;
    pend_set   = '0;
    pend_clr   = '0;
    sweep_d    = sweep_q;
    if (sweep_q) begin
      if (!found || !en) begin
        sweep_d = 1'b0;
      end else if (slot_free) begin
        launch          = 1'b1;
        launch_vec      = first;
        pend_clr[first] = 1'b1;
      end
    end else if (irq_valid && irq_ready && en && vec_ok) begin
      if (MASKING && mask[irq_vec]) pend_set[irq_vec] = 1'b1;
      else                          launch = 1'b1;
    end
    if (post_q && en && MASKING) sweep_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      post_q  <= 1'b0;
      sweep_q <= 1'b0;
    end else begin
      post_q  <= wr_hit;
      sweep_q <= sweep_d;
    end
  end

  assign post_step     = post_q;
  assign sweeping      = sweep_q;
  assign intx_deassert = post_q && en;

endmodule

// File: rtl/msi_cap_msg.sv
module msi_cap_msg
  import msi_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [4:0]  vec,
  input  logic [2:0]  qsize,
  input  logic [63:0] addr_in,
  input  logic [15:0] data_in,
  input  logic        msg_ready,
  output logic        msg_valid,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data,
  output logic        slot_free
);

  msg_t pkt_q, pkt_d;
  logic valid_q, valid_d;
  logic [31:0] low_m;

  assign slot_free = !valid_q || msg_ready;

  always_comb begin
    low_m      = (32'd1 << qsize) - 32'd1;
    pkt_d.addr = addr_in;
    pkt_d.data = ({16'h0000, data_in} & ~low_m) | ({27'b0, vec} & low_m);
    pkt_d.data[31:16] = 16'h0000;
    if (launch)         valid_d = 1'b1;
    else if (msg_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Payload register with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= '0;
    else if (launch) pkt_q <= pkt_d;
  end

  assign msg_valid = valid_q;
  assign msg_addr  = pkt_q.addr;
  assign msg_data  = pkt_q.data;

endmodule

// File: rtl/msi_cap_unit.sv
module msi_cap_unit
  import msi_cap_pkg::*;
#(
  parameter int unsigned CAP_LOG2 = 3,
  parameter bit          ADDR64   = 1'b1,
  parameter bit          MASKING  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        irq_valid,
  input  logic [4:0]  irq_vec,
  output logic        irq_ready,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data,
  output logic        intx_deassert
);

  logic [1:0]         rsync_q;
  logic               rst_sync;
  logic               wr_hit, post_step, sweeping, launch, slot_free, en;
  logic [2:0]         qs;
  logic [4:0]         launch_vec;
  logic [63:0]        addr;
  logic [15:0]        data16;
  logic [VEC_MAX-1:0] mask, pend, pend_set, pend_clr;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync = rsync_q[1];

  msi_cap_regs #(.CAP_LOG2(CAP_LOG2), .ADDR64(ADDR64), .MASKING(MASKING)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr_en(cfg_wr), .dw_idx(cfg_dw), .wr_be(cfg_be),
    .wr_data(cfg_wdata), .rd_data(cfg_rdata), .wr_hit(wr_hit), .post_step(post_step),
    .pend_set(pend_set), .pend_clr(pend_clr), .en(en), .qsize(qs), .addr(addr),
    .data16(data16), .mask(mask), .pend(pend)
  );

  msi_cap_seq #(.MASKING(MASKING)) u_seq (
    .clk(clk), .rst_n(rst_sync), .wr_hit(wr_hit), .en(en), .qsize(qs), .mask(mask),
    .pend(pend), .irq_valid(irq_valid), .irq_vec(irq_vec), .slot_free(slot_free),
    .irq_ready(irq_ready), .post_step(post_step), .sweeping(sweeping), .launch(launch),
    .launch_vec(launch_vec), .pend_set(pend_set), .pend_clr(pend_clr),
    .intx_deassert(intx_deassert)
  );

  msi_cap_msg u_msg (
    .clk(clk), .rst_n(rst_sync), .launch(launch), .vec(launch_vec), .qsize(qs),
    .addr_in(addr), .data_in(data16), .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .slot_free(slot_free)
  );

endmodule

// File: rtl/msi_cap_unit_chk.sv
module msi_cap_unit_chk #(
  parameter int unsigned CAP_LOG2 = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data,
  input logic        irq_ready,
  input logic        sweeping,
  input logic [2:0]  qsize
);

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |-> !irq_ready);

  // R10
  replay_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !irq_ready);

  // R5
  data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[31:16] == 16'h0000);

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[1:0] == 2'b00);

  // R9
  clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> 32'(qsize) <= CAP_LOG2);

endmodule

bind msi_cap_unit msi_cap_unit_chk #(.CAP_LOG2(CAP_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_sync), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .irq_ready(irq_ready),
  .sweeping(sweeping), .qsize(qs)
);

// File: tb/msi_cap_unit_test.sv
module msi_cap_unit_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_valid = 1'b0;
  logic [4:0]  irq_vec = '0;
  logic        irq_ready;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic        intx_deassert;

  int errors = 0;
  int checks = 0;
  int nlog = 0;
  int npulse = 0;
  logic [31:0] msg_log [32];

  always #(PERIOD/2) clk = ~clk;

  msi_cap_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_valid(irq_valid),
    .irq_vec(irq_vec), .irq_ready(irq_ready), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
    .intx_deassert(intx_deassert)
  );

  // Message and pulse monitors, sampled after the falling edge
  always @(negedge clk) begin
    #1;
    if (msg_valid && msg_ready) begin
      if (nlog < 32) msg_log[nlog] = msg_data;
      nlog++;
    end
    if (intx_deassert) npulse++;
  end

  // Table: {dword, byte enables, write data, expected readback}
  localparam int NV = 9;
  localparam logic [70:0] VEC [NV] = '{
    {3'd1, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFC},
    {3'd2, 4'hF, 32'h1234_5678, 32'h1234_5678},
    {3'd3, 4'hF, 32'hFFFF_FFFF, 32'h0000_FFFF},
    {3'd4, 4'hF, 32'hFFFF_FFFF, 32'h0000_00FF},
    {3'd5, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},
    {3'd1, 4'h2, 32'h0000_5A00, 32'hFFFF_5AFC},
    {3'd0, 4'hC, 32'h0000_0000, 32'h0186_0000},
    {3'd0, 4'hC, 32'hFFFF_FFFF, 32'h01B7_0000},
    {3'd0, 4'hC, 32'h0000_0000, 32'h0186_0000}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2, 5: return "R2";
      3:          return "R3";
      4:          return "R12";
      7:          return "R9";
      default:    return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    idle(4);
  endtask

  task automatic cfg_read(input logic [2:0] dw, output logic [31:0] v);
    @(negedge clk);
    cfg_dw = dw;
    #1 v = cfg_rdata;
  endtask

  task automatic send_irq(input logic [4:0] v);
    int n;
    @(negedge clk);
    irq_vec = v; irq_valid = 1'b1;
    n = 0;
    #1;
    while (!irq_ready && n < 100) begin
      @(negedge clk); #1; n++;
    end
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    int k;
    k = 0;
    while (nlog < n && k < 60) begin
      @(negedge clk); k++;
    end
    idle(1);
  endtask

  logic [31:0] rv;

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0, n0;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1: reset state
    cfg_read(3'd0, rv); check("R1 ctrl", 64'(rv), 64'h0186_0000);
    for (int d = 1; d < 6; d++) begin
      cfg_read(3'(d), rv); check("R1 reg", 64'(rv), 64'h0);
    end
    check("R1 msg_valid", 64'(msg_valid), 64'h0);

    // Table walk: write then read back
    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][70:68], VEC[i][67:64], VEC[i][63:32]);
      cfg_read(VEC[i][70:68], rv);
      check(tag_of(i), 64'(rv), 64'(VEC[i][31:0]));
    end

    // Setup for message tests, enable with E=2 (4 vectors)
    cfg_write(3'd1, 4'hF, 32'h1000_0040);
    cfg_write(3'd2, 4'hF, 32'h0000_0001);
    cfg_write(3'd3, 4'hF, 32'h0000_ABCD);
    cfg_write(3'd4, 4'hF, 32'h0000_0000);
    c0 = npulse;
    cfg_write(3'd0, 4'hC, 32'h0021_0000);
    check("R8 pulse on enabling write", 64'(npulse - c0), 64'd1);

    // R5 / R11: message held while not ready
    msg_ready = 1'b0;
    n0 = nlog;
    send_irq(5'd3);
    idle(1);
    check("R5 valid", 64'(msg_valid), 64'd1);
    check("R5 addr", msg_addr, 64'h0000_0001_1000_0040);
    check("R5 data", 64'(msg_data), 64'h0000_ABCF);
    check("R11 ready low", 64'(irq_ready), 64'd0);
    idle(3);
    check("R11 held", 64'({msg_valid, msg_data}), 64'({1'b1, 32'h0000_ABCF}));
    msg_ready = 1'b1;
    wait_log(n0 + 1);
    check("R11 one message", 64'(nlog - n0), 64'd1);
    check("R11 released", 64'(msg_valid), 64'd0);

    // R7: out-of-range vector and disabled requests
    n0 = nlog;
    send_irq(5'd5);
    idle(4);
    check("R7 out of range no msg", 64'(nlog - n0), 64'd0);
    cfg_read(3'd5, rv); check("R7 out of range no pend", 64'(rv), 64'd0);
    cfg_write(3'd0, 4'hC, 32'h0020_0000);
    send_irq(5'd1);
    idle(4);
    check("R7 disabled no msg", 64'(nlog - n0), 64'd0);
    cfg_read(3'd5, rv); check("R7 disabled no pend", 64'(rv), 64'd0);
    cfg_write(3'd0, 4'hC, 32'h0021_0000);

    // R6: masked requests go pending
    cfg_write(3'd4, 4'hF, 32'h0000_000A);
    n0 = nlog;
    send_irq(5'd1);
    send_irq(5'd3);
    idle(4);
    check("R6 no msg", 64'(nlog - n0), 64'd0);
    cfg_read(3'd5, rv); check("R6 pending", 64'(rv), 64'h0A);
    send_irq(5'd2);
    wait_log(n0 + 1);
    check("R6 unmasked msg", 64'(msg_log[n0]), 64'h0000_ABCE);

    // R10: unmask vector 1 -> replay
    n0 = nlog;
    cfg_write(3'd4, 4'hF, 32'h0000_0008);
    wait_log(n0 + 1);
    check("R10 replay count", 64'(nlog - n0), 64'd1);
    check("R10 replay data", 64'(msg_log[n0]), 64'h0000_ABCD);
    cfg_read(3'd5, rv); check("R10 pending left", 64'(rv), 64'h08);
    // R10: shrink E to 1 (2 vectors) drops pending vector 3
    cfg_write(3'd0, 4'hC, 32'h0011_0000);
    cfg_read(3'd5, rv); check("R10 discard", 64'(rv), 64'h0);
    check("R10 discard no msg", 64'(nlog - n0), 64'd1);
    // R10: ascending replay order
    cfg_write(3'd0, 4'hC, 32'h0021_0000);
    cfg_write(3'd4, 4'hF, 32'h0000_000F);
    send_irq(5'd3);
    send_irq(5'd2);
    send_irq(5'd0);
    idle(3);
    cfg_read(3'd5, rv); check("R10 pending set", 64'(rv), 64'h0D);
    n0 = nlog;
    cfg_write(3'd4, 4'hF, 32'h0000_0000);
    wait_log(n0 + 3);
    check("R10 order 0", 64'(msg_log[n0]),     64'h0000_ABCC);
    check("R10 order 2", 64'(msg_log[n0 + 1]), 64'h0000_ABCE);
    check("R10 order 3", 64'(msg_log[n0 + 2]), 64'h0000_ABCF);
    cfg_read(3'd5, rv); check("R10 pending cleared", 64'(rv), 64'h0);

    // R8: writes outside the capability or with no lanes
    c0 = npulse;
    cfg_write(3'd7, 4'hF, 32'hFFFF_FFFF);
    cfg_write(3'd3, 4'h0, 32'hFFFF_FFFF);
    check("R8 no pulse outside", 64'(npulse - c0), 64'd0);
    cfg_read(3'd3, rv); check("R8 data untouched", 64'(rv), 64'h0000_ABCD);
    cfg_write(3'd3, 4'h1, 32'h0000_00CD);
    check("R8 pulse inside", 64'(npulse - c0), 64'd1);

    // R5: E=0 leaves data untouched
    cfg_write(3'd0, 4'hC, 32'h0001_0000);
    n0 = nlog;
    send_irq(5'd0);
    wait_log(n0 + 1);
    check("R5 single vector data", 64'(msg_log[n0]), 64'h0000_ABCD);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule